// File: doc/BRIEF.md
# Entropy Source Health Monitor

This block sits directly behind one digitized physical noise source. Each incoming sample goes through four continuous online tests: a repetition-run test, a window mean test, a window variance test and a per-symbol frequency test. Any failed test sets its own sticky fault bit. The bits stay set until a clear strobe arrives. An enable input can also hold back the normal entropy output while a fault is present.

In normal mode the monitor whitens the least significant bit of each sample with a von Neumann pair rule. It packs the surviving bits into words and offers each word on a valid/ready interface. In debug mode the normal output is disabled and raw samples are echoed on a separate port. Anything buffered toward the normal output when debug mode is entered is discarded. The test thresholds are static configuration inputs, expected to be driven from control registers outside the block.

Top module: `ent_health_mon`

## Requirements
- R1: Fault bit 0 (run) sets on the clock edge of a sample that equals the previous sample while the current run length (previous sample included) is already at least `max_run_i`. A run of exactly `max_run_i` identical samples does not set it.
- R2: Fault bit 1 (mean) sets when |floor(sum/N) − `mean_exp_i`| > `mean_tol_i` for a completed window.
- R3: Fault bit 2 (variance) sets when floor(sumsq/N) − floor(sum/N)² < `min_var_i` for a completed window.
- R4: Fault bit 3 (frequency) sets when, in a completed window, the occurrence count of any of the 2^SAMPLE_W symbol values is below `freq_lo_i` or above `freq_hi_i`.
- R5: A window holds N = 2^WIN_LOG2 accepted samples. Window tests are evaluated only after the N-th sample, with their bits updating within two cycles. Statistics then restart from zero.
- R6: Fault bits are sticky. `err_o` is the OR of `err_flags_o`. A `clear_err_i` strobe clears all bits on the next edge. After reset all bits are 0.
- R7: While `block_i` and `err_o` are both high, `word_valid_o` is low. The pending word is kept and reappears once the fault is cleared.
- R8: In debug mode, `raw_valid_o` is high for the cycle after each accepted sample and `raw_o` carries that sample. Outside debug mode `raw_valid_o` stays low.
- R9: While `debug_i` is high, `word_valid_o` is low. Debug mode discards any pending word, partial word and half pair, and samples taken in debug mode never reach the packer.
- R10: Whitening works on sample bit 0 in consecutive non-overlapping pairs. The pair (1,0) yields 1, the pair (0,1) yields 0, and equal pairs yield nothing.
- R11: The k-th whitened bit goes to `word_o[k]`. `word_valid_o` rises after the 32nd bit. A word transfers when valid and `word_ready_i` are both high. Bits whitened while a word is pending are dropped, and the pending word stays stable.
- R12: After reset, `word_valid_o`, `raw_valid_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | SAMPLE_W | Digitized noise sample |
| debug_i | input | 1 | Debug mode select |
| block_i | input | 1 | Withhold normal output while a fault is set |
| clear_err_i | input | 1 | Clears all fault bits |
| max_run_i | input | RUN_W | Longest permitted run of identical samples |
| mean_exp_i | input | SAMPLE_W | Expected window mean |
| mean_tol_i | input | SAMPLE_W | Permitted mean deviation |
| min_var_i | input | 2*SAMPLE_W | Minimum window variance |
| freq_lo_i | input | WIN_LOG2+1 | Minimum count per symbol |
| freq_hi_i | input | WIN_LOG2+1 | Maximum count per symbol |
| word_o | output | WORD_W | Packed whitened word |
| word_valid_o | output | 1 | Word available |
| word_ready_i | input | 1 | Consumer accepts word |
| raw_o | output | SAMPLE_W | Raw sample in debug mode |
| raw_valid_o | output | 1 | Raw sample strobe |
| err_o | output | 1 | Any fault present |
| err_flags_o | output | 4 | Fault bits: 0 run, 1 mean, 2 variance, 3 frequency |

## Verification
The bench targets the run-length boundary, where exactly the limit passes and one more sample fails. A comparison off by one in either direction would flag clean sources or miss stuck ones. It checks that window faults stay quiet until the last sample of a window. A design that tested partial statistics would flag early. It drives a stimulus where only the mean is off and one where the symbols are badly skewed, so a swapped fault bit shows up. It checks that a word pending at debug entry is gone afterwards, and that a blocked word comes back intact after a clear. A design that leaked debug-era data or dropped words would fail these.

// File: rtl/ehm_pkg.sv
package ehm_pkg;
  localparam int unsigned NUM_TESTS = 4;
  typedef enum int unsigned {
    T_RUN  = 0,
    T_MEAN = 1,
    T_VAR  = 2,
    T_FREQ = 3
  } test_e;
endpackage

// File: rtl/ehm_run_test.sv
module ehm_run_test #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned RUN_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [RUN_W-1:0]    max_run_i,
  output logic                fail_o
);
  logic [SAMPLE_W-1:0] prev_q;
  logic                have_q;
  logic [RUN_W-1:0]    run_q;
  logic                same;

  assign same   = valid_i && have_q && (sample_i == prev_q);
  assign fail_o = same && (run_q >= max_run_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      have_q <= 1'b0;
      run_q  <= '0;
    end else if (valid_i) begin
      prev_q <= sample_i;
      have_q <= 1'b1;
      if (same) run_q <= (run_q == '1) ? run_q : run_q + 1'b1;
      else      run_q <= RUN_W'(1);
    end
  end

  assert_run_nonzero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_q |-> (run_q != '0));
endmodule

// File: rtl/ehm_window_stats.sv
module ehm_window_stats #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned WIN_LOG2 = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [SAMPLE_W-1:0]   sample_i,
  input  logic [SAMPLE_W-1:0]   mean_exp_i,
  input  logic [SAMPLE_W-1:0]   mean_tol_i,
  input  logic [2*SAMPLE_W-1:0] min_var_i,
  input  logic [WIN_LOG2:0]     freq_lo_i,
  input  logic [WIN_LOG2:0]     freq_hi_i,
  output logic                  fail_mean_o,
  output logic                  fail_var_o,
  output logic                  fail_freq_o
);
  localparam int unsigned SUM_W = SAMPLE_W + WIN_LOG2;
  localparam int unsigned SQ_W  = 2*SAMPLE_W + WIN_LOG2;
  localparam int unsigned CW    = WIN_LOG2 + 1;
  localparam int unsigned NSYM  = 1 << SAMPLE_W;

  logic [SUM_W-1:0]    sum_q;
  logic [SQ_W-1:0]     sq_q;
  logic [CW-1:0]       hist_q [NSYM];
  logic [WIN_LOG2-1:0] cnt_q;
  logic                eval_q;

  logic [2*SAMPLE_W-1:0] x_sq, msq, mean2, var_est;
  logic [SAMPLE_W-1:0]   mean, dev;
  logic                  freq_bad;

  assign x_sq    = {{SAMPLE_W{1'b0}}, sample_i} * {{SAMPLE_W{1'b0}}, sample_i};
  assign mean    = SAMPLE_W'(sum_q >> WIN_LOG2);
  assign msq     = (2*SAMPLE_W)'(sq_q >> WIN_LOG2);
  assign mean2   = {{SAMPLE_W{1'b0}}, mean} * {{SAMPLE_W{1'b0}}, mean};
  assign var_est = msq - mean2;
  assign dev     = (mean > mean_exp_i) ? mean - mean_exp_i : mean_exp_i - mean;

  always_comb begin
    freq_bad = 1'b0;
    for (int i = 0; i < NSYM; i++)
      if (hist_q[i] < freq_lo_i || hist_q[i] > freq_hi_i) freq_bad = 1'b1;
  end

  assign fail_mean_o = eval_q && (dev > mean_tol_i);
  assign fail_var_o  = eval_q && (var_est < min_var_i);
  assign fail_freq_o = eval_q && freq_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      sq_q   <= '0;
      cnt_q  <= '0;
      eval_q <= 1'b0;
      for (int i = 0; i < NSYM; i++) hist_q[i] <= '0;
    end else if (eval_q) begin
      // restart statistics; a sample arriving now opens the next window
      eval_q <= 1'b0;
      sum_q  <= valid_i ? SUM_W'(sample_i) : '0;
      sq_q   <= valid_i ? SQ_W'(x_sq) : '0;
      cnt_q  <= valid_i ? WIN_LOG2'(1) : '0;
      for (int i = 0; i < NSYM; i++)
        hist_q[i] <= (valid_i && sample_i == SAMPLE_W'(i)) ? CW'(1) : '0;
    end else if (valid_i) begin
      sum_q  <= sum_q + SUM_W'(sample_i);
      sq_q   <= sq_q + SQ_W'(x_sq);
      cnt_q  <= cnt_q + 1'b1;
      eval_q <= (cnt_q == '1);
      hist_q[sample_i] <= hist_q[sample_i] + CW'(1);
    end
  end

  assert_eval_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_q |=> !eval_q);
  assert_eval_at_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eval_q) |-> (cnt_q == '0));
endmodule

// File: rtl/ehm_whiten_pack.sv
module ehm_whiten_pack #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              valid_i,
  input  logic              bit_i,
  input  logic              take_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic              have_q, first_q, full_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word_q;
  logic              wb_valid;

  assign wb_valid = valid_i && have_q && (first_q != bit_i);
  assign word_o   = word_q;
  assign full_o   = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q  <= 1'b0;
      first_q <= 1'b0;
      full_q  <= 1'b0;
      cnt_q   <= '0;
      word_q  <= '0;
    end else if (flush_i) begin
      have_q <= 1'b0;
      full_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (take_i) full_q <= 1'b0;
      if (valid_i) begin
        have_q  <= !have_q;
        first_q <= bit_i;
      end
      if (wb_valid && !full_q) begin
        word_q[cnt_q] <= first_q;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(WORD_W-1)) full_q <= 1'b1;
      end
    end
  end

  assert_word_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !take_i && !flush_i) |=> (full_q && $stable(word_q)));
  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !full_q);
endmodule

// File: rtl/ent_health_mon.sv
module ent_health_mon #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned WIN_LOG2 = 12,
  parameter int unsigned RUN_W    = 8,
  parameter int unsigned WORD_W   = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sample_valid_i,
  input  logic [SAMPLE_W-1:0]   sample_i,
  input  logic                  debug_i,
  input  logic                  block_i,
  input  logic                  clear_err_i,
  input  logic [RUN_W-1:0]      max_run_i,
  input  logic [SAMPLE_W-1:0]   mean_exp_i,
  input  logic [SAMPLE_W-1:0]   mean_tol_i,
  input  logic [2*SAMPLE_W-1:0] min_var_i,
  input  logic [WIN_LOG2:0]     freq_lo_i,
  input  logic [WIN_LOG2:0]     freq_hi_i,
  output logic [WORD_W-1:0]     word_o,
  output logic                  word_valid_o,
  input  logic                  word_ready_i,
  output logic [SAMPLE_W-1:0]   raw_o,
  output logic                  raw_valid_o,
  output logic                  err_o,
  output logic [3:0]            err_flags_o
);
  import ehm_pkg::*;

  logic [NUM_TESTS-1:0] fail, err_q;
  logic                 full, take, norm_valid;
  logic [SAMPLE_W-1:0]  raw_q;
  logic                 raw_valid_q;

  ehm_run_test #(.SAMPLE_W(SAMPLE_W), .RUN_W(RUN_W)) u_run (
    .clk_i, .rst_ni,
    .valid_i  (sample_valid_i),
    .sample_i (sample_i),
    .max_run_i(max_run_i),
    .fail_o   (fail[T_RUN])
  );

  ehm_window_stats #(.SAMPLE_W(SAMPLE_W), .WIN_LOG2(WIN_LOG2)) u_win (
    .clk_i, .rst_ni,
    .valid_i    (sample_valid_i),
    .sample_i   (sample_i),
    .mean_exp_i (mean_exp_i),
    .mean_tol_i (mean_tol_i),
    .min_var_i  (min_var_i),
    .freq_lo_i  (freq_lo_i),
    .freq_hi_i  (freq_hi_i),
    .fail_mean_o(fail[T_MEAN]),
    .fail_var_o (fail[T_VAR]),
    .fail_freq_o(fail[T_FREQ])
  );

  assign norm_valid = sample_valid_i && !debug_i;

  ehm_whiten_pack #(.WORD_W(WORD_W)) u_pack (
    .clk_i, .rst_ni,
    .flush_i(debug_i),
    .valid_i(norm_valid),
    .bit_i  (sample_i[0]),
    .take_i (take),
    .word_o (word_o),
    .full_o (full)
  );

  assign err_o        = |err_q;
  assign err_flags_o  = err_q;
  assign word_valid_o = full && !debug_i && !(block_i && err_o);
  assign take         = word_valid_o && word_ready_i;
  assign raw_o        = raw_q;
  assign raw_valid_o  = raw_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q       <= '0;
      raw_q       <= '0;
      raw_valid_q <= 1'b0;
    end else begin
      err_q       <= (clear_err_i ? '0 : err_q) | fail;
      raw_valid_q <= debug_i && sample_valid_i;
      if (debug_i && sample_valid_i) raw_q <= sample_i;
    end
  end

  assert_no_word_in_debug_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_i |-> !word_valid_o);
  assert_no_raw_outside_debug_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(debug_i) |-> !raw_valid_o);
  assert_block_gates_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_i && err_o) |-> !word_valid_o);
  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_err_i |=> ((err_flags_o & $past(err_flags_o)) == $past(err_flags_o)));
endmodule

// File: tb/sim_ent_health_mon.sv
module sim_ent_health_mon;
  localparam int SW = 4;
  localparam int WL = 6;
  localparam int N  = 1 << WL;

  // {base, step, expected fault bits}
  localparam logic [11:0] VEC [5] = '{
    {4'd0,  4'd1, 4'b0000},
    {4'd5,  4'd0, 4'b1101},
    {4'd0,  4'd3, 4'b0000},
    {4'd0,  4'd8, 4'b1010},
    {4'd15, 4'd0, 4'b1111}
  };

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, debug = 0, block = 0, clr = 0, ready = 0;
  logic [SW-1:0] s_data = '0;
  logic [7:0] max_run = 8'd3;
  logic [SW-1:0] mean_exp = 4'd7, mean_tol = 4'd2;
  logic [2*SW-1:0] min_var = 8'd10;
  logic [WL:0] f_lo = 7'd2, f_hi = 7'd6;
  logic [31:0] word;
  logic word_valid, raw_valid, err;
  logic [SW-1:0] raw;
  logic [3:0] flags;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ent_health_mon #(.SAMPLE_W(SW), .WIN_LOG2(WL), .RUN_W(8), .WORD_W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(s_valid), .sample_i(s_data),
    .debug_i(debug), .block_i(block), .clear_err_i(clr), .max_run_i(max_run),
    .mean_exp_i(mean_exp), .mean_tol_i(mean_tol), .min_var_i(min_var),
    .freq_lo_i(f_lo), .freq_hi_i(f_hi), .word_o(word), .word_valid_o(word_valid),
    .word_ready_i(ready), .raw_o(raw), .raw_valid_o(raw_valid), .err_o(err),
    .err_flags_o(flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [SW-1:0] x);
    @(negedge clk); s_valid = 1; s_data = x;
    @(negedge clk); s_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags;
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic pair(input logic b);
    if (b) begin send(4'd1); send(4'd2); end
    else   begin send(4'd2); send(4'd1); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] exp_w;
    idle(2);
    chk("R12 valid", {31'd0, word_valid}, 0);
    chk("R12 raw_valid", {31'd0, raw_valid}, 0);
    chk("R12 err", {27'd0, err, flags}, 0);
    rst_n = 1;
    idle(2);
    ready = 1;

    for (int v = 0; v < 5; v++) begin
      logic [3:0] base, step, expf;
      {base, step, expf} = VEC[v];
      clear_flags();
      chk("R6 clear", {28'd0, flags}, 0);
      for (int i = 0; i < N - 1; i++) send(4'(base + step * i));
      idle(3);
      chk("R5 no window fault before window end", {29'd0, flags[3:1]}, 0);
      send(4'(base + step * (N - 1)));
      idle(3);
      chk("R1 R2 R3 R4 fault bits", {28'd0, flags}, {28'd0, expf});
      chk("R6 err is OR", {31'd0, err}, {31'd0, |expf});
      idle(4);
      chk("R6 sticky", {28'd0, flags}, {28'd0, expf});
    end

    // lax window thresholds for the directed part
    mean_tol = 4'd15; min_var = '0; f_lo = '0; f_hi = '1;
    ready = 0;
    clear_flags();

    // R1 boundary
    send(4'd9); send(4'd9); send(4'd9);
    idle(1);
    chk("R1 run equal to limit", {31'd0, flags[0]}, 0);
    send(4'd9);
    chk("R1 run beyond limit", {31'd0, flags[0]}, 1);
    clear_flags();

    // R10 R11 whitening and packing
    @(negedge clk); debug = 1;
    @(negedge clk); debug = 0;
    exp_w = '0;
    for (int k = 0; k < 32; k++) begin
      exp_w[k] = (k % 3 == 0);
      pair(exp_w[k]);
      if (k == 15) begin send(4'd3); send(4'd5); end
      if (k == 30) chk("R11 not valid before 32 bits", {31'd0, word_valid}, 0);
    end
    chk("R11 valid after 32 bits", {31'd0, word_valid}, 1);
    chk("R10 R11 packed word", word, exp_w);
    pair(1'b0); pair(1'b1);
    chk("R11 word held while pending", word, exp_w);
    @(negedge clk); ready = 1;
    @(negedge clk); ready = 0;
    chk("R11 handshake transfers", {31'd0, word_valid}, 0);

    // R7 blocking
    for (int k = 0; k < 32; k++) pair(1'b1);
    send(4'd6); send(4'd6); send(4'd6); send(4'd6);
    block = 1;
    @(negedge clk);
    chk("R7 err set", {31'd0, err}, 1);
    chk("R7 blocked valid", {31'd0, word_valid}, 0);
    clear_flags();
    chk("R7 word back after clear", {31'd0, word_valid}, 1);
    chk("R7 word intact", word, 32'hFFFF_FFFF);
    block = 0;

    // R8 R9 debug
    @(negedge clk); debug = 1;
    @(negedge clk);
    chk("R9 no word in debug", {31'd0, word_valid}, 0);
    send(4'd9);
    chk("R8 raw valid in debug", {31'd0, raw_valid}, 1);
    chk("R8 raw data", {28'd0, raw}, 32'd9);
    for (int k = 0; k < 31; k++) pair(1'b1);
    @(negedge clk); debug = 0;
    idle(2);
    chk("R9 pending word discarded", {31'd0, word_valid}, 0);
    pair(1'b1);
    chk("R9 debug bits not packed", {31'd0, word_valid}, 0);
    send(4'd7);
    chk("R8 no raw outside debug", {31'd0, raw_valid}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule